// File: doc/BRIEF.md
# Sequential Single-MAC FIR Filter

This block computes a finite impulse response filter with a single multiplier and a single accumulator. The taps are handled one per clock cycle, so each output costs TAPS cycles. The hardware cost is one MAC no matter how long the filter is. The price is throughput: the block produces one result per TAPS clock cycles.

Input samples arrive on a valid/ready handshake and enter a shift-register history buffer. The coefficients sit in a small read-only table. The table is fixed at elaboration from an array parameter and is addressed by the same tap index that selects the history entry.

The accumulator is as wide as the worst-case bit growth needs. At the start of every output it is loaded with a rounding bias rather than cleared. The finished sum is shifted right to drop the fractional bits, and its low bits are kept as the output word.

Top module: `seq_fir`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `in_ready` is 1, `out_y` is 0, and the whole sample history reads as zero.
- R2: A sample is taken only on a clock edge where `in_valid` and `in_ready` are both 1. After such an edge, `in_ready` stays at 0 for exactly TAPS-1 cycles.
- R3: While `in_ready` is 0, the value and validity of `in_data` have no effect on any later output.
- R4: `out_valid` is high for one cycle only, and it rises exactly TAPS cycles after the edge that took the sample. `out_y` changes only together with `out_valid`.
- R5: The result is the sum over k of `COEFS[k]` times the k-th most recent accepted sample. Index 0 is the sample taken last.
- R6: Every sum starts from the bias 2^(FRAC-1)-1, or from 0 when FRAC is 0, and never from the previous result.
- R7: `out_y` is the full-precision sum shifted right arithmetically by FRAC bits and cut to its low OUT_W bits. No saturation is applied, so values out of range wrap.
- R8: The accumulator is DATA_W+COEF_W+ceil(log2(TAPS)) bits wide. It holds full-scale negative inputs and coefficients without overflow.
- R9: A new sample can be taken in the last tap cycle of the current result. With `in_valid` held high, outputs come exactly TAPS cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_y | output | OUT_W | Rounded, truncated signed result |

## Verification
Take the edge that accepts a sample as edge 0. `in_ready` falls right after that edge and rises again after edge TAPS-1. `out_valid` and a new `out_y` appear after edge TAPS. The bench keeps a behavioural model that is updated on the same rising edge as the design. On every falling edge it compares `in_ready`, `out_valid` and `out_y` against that model, which places each check mid-cycle in exactly the cycle the result is due. Apart from this, separate checks time the gap between consecutive strobes while the input is held valid, and confirm the reset state at the port.

// File: rtl/seq_fir_pkg.sv
package seq_fir_pkg;

  // Control strobes decoded from the tap sequencer.
  typedef struct packed {
    logic run;    // a result is being accumulated
    logic first;  // tap 0: seed the accumulator with the bias
    logic last;   // final tap: the result completes on this edge
  } tap_ctl_t;

  // Rounding bias added once per result.
  function automatic longint round_seed(input int frac);
    if (frac > 0) return (64'sd1 <<< (frac - 1)) - 64'sd1;
    return 64'sd0;
  endfunction

  // Index width for a count that is never below one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fir_tap_ctrl.sv
module fir_tap_ctrl
  import seq_fir_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             accept,
  output tap_ctl_t         ctl,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAPS - 1);

  logic             run_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_tap;

  assign last_tap  = run_q && (idx_q == LAST_IDX);
  assign in_ready  = !run_q || last_tap;
  assign accept    = in_valid && in_ready;
  assign idx       = idx_q;
  assign ctl.run   = run_q;
  assign ctl.first = run_q && (idx_q == '0);
  assign ctl.last  = last_tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else if (accept) begin
      run_q <= 1'b1;
      idx_q <= '0;
    end else if (last_tap) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else if (run_q) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [DATA_W-1:0] dout
);

  logic signed [DATA_W-1:0] stage_q [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) stage_q[i] <= '0;
    end else if (shift_en) begin
      stage_q[0] <= din;
      for (int i = 1; i < TAPS; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[rd_idx];

endmodule

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
  parameter int COEF_W = 16,
  parameter int TAPS   = 8,
  parameter int IDX_W  = 3,
  parameter logic signed [COEF_W-1:0] COEFS [TAPS] = '{default: '0}
) (
  input  logic [IDX_W-1:0]         addr,
  output logic signed [COEF_W-1:0] data
);

  logic signed [COEF_W-1:0] table_w [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_entry
    assign table_w[g] = COEFS[g];
  end

  assign data = table_w[addr];

endmodule

// File: rtl/fir_mac.sv
module fir_mac
  import seq_fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 35,
  parameter int FRAC   = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  tap_ctl_t                 ctl,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  sum_next
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic signed [ACC_W-1:0] BIAS = ACC_W'(round_seed(FRAC));

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  base;

  assign prod     = sample * coef;
  assign base     = ctl.first ? BIAS : acc_q;
  assign sum_next = base + ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (ctl.run) acc_q <= sum_next;
  end

endmodule

// File: rtl/seq_fir.sv
module seq_fir
  import seq_fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 8,
  parameter int FRAC   = 15,
  parameter int OUT_W  = 18,
  parameter logic signed [COEF_W-1:0] COEFS [TAPS] = '{
    16'sd1200, -16'sd3000, 16'sd9000, 16'sd20000,
    16'sd20000, 16'sd9000, -16'sd3000, 16'sd1200}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_y
);

  localparam int IDX_W  = idx_bits(TAPS);
  localparam int GROW_W = (TAPS > 1) ? $clog2(TAPS) : 0;
  localparam int ACC_W  = DATA_W + COEF_W + GROW_W;

  logic                     accept;
  tap_ctl_t                 ctl;
  logic [IDX_W-1:0]         idx;
  logic signed [DATA_W-1:0] sample;
  logic signed [COEF_W-1:0] coef;
  logic signed [ACC_W-1:0]  sum_next;

  fir_tap_ctrl #(.TAPS(TAPS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .ctl(ctl), .idx(idx)
  );

  fir_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS), .IDX_W(IDX_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(accept), .din($signed(in_data)),
    .rd_idx(idx), .dout(sample)
  );

  fir_coef_rom #(.COEF_W(COEF_W), .TAPS(TAPS), .IDX_W(IDX_W), .COEFS(COEFS)) u_rom (
    .addr(idx), .data(coef)
  );

  fir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst(rst), .ctl(ctl), .sample(sample), .coef(coef), .sum_next(sum_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= ctl.last;
      if (ctl.last) out_y <= OUT_W'(sum_next >>> FRAC);
    end
  end

endmodule

// File: rtl/seq_fir_chk.sv
module seq_fir_chk #(
  parameter int TAPS  = 8,
  parameter int OUT_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_y
);

  int low_run;

  always_ff @(posedge clk) begin
    if (rst || in_ready) low_run <= 0;
    else low_run <= low_run + 1;
  end

  // R4: the result word changes only together with the strobe
  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_y));

  if (TAPS > 1) begin : g_multi
    // R2: taking a sample closes the handshake for the next cycle
    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

    // R2: the busy stretch never outlasts TAPS-1 cycles
    a_r2_busy_length: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> (low_run < TAPS - 1));

    // R4: single-cycle strobe
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

    // R9: a result lands just after a cycle in which the input was open
    a_r9_open_on_last: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(in_ready));
  end

endmodule

bind seq_fir seq_fir_chk #(.TAPS(TAPS), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_y(out_y)
);

// File: tb/test_seq_fir.sv
module test_seq_fir;

  localparam int DATA_W = 16;
  localparam int COEF_W = 16;
  localparam int TAPS   = 8;
  localparam int FRAC   = 15;
  localparam int OUT_W  = 16;
  localparam int WD_LIMIT = 100000;
  localparam logic signed [COEF_W-1:0] TB_COEFS [TAPS] = '{
    16'sd1200, -16'sd3000, 16'sd9000, 16'sd20000,
    16'sd20000, 16'sd9000, -16'sd3000, 16'sd1200};
  localparam longint BIAS = (64'sd1 <<< (FRAC - 1)) - 64'sd1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic [OUT_W-1:0]  out_y;

  always #2.5 clk = ~clk;

  seq_fir #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .FRAC(FRAC),
            .OUT_W(OUT_W), .COEFS(TB_COEFS)) i_seq_fir (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_y(out_y)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit checking = 0;
  bit b2b = 0;
  string phase = "R1 reset";

  // behavioural reference, advanced on the same rising edge as the design
  int               hist[$];
  int               m_cnt;
  bit               m_valid;
  logic [OUT_W-1:0] m_y;

  always @(posedge clk) begin
    bit     rdy;
    longint s;
    longint t;
    if (rst) begin
      hist = {};
      for (int i = 0; i < TAPS; i++) hist.push_back(0);
      m_cnt = -1; m_valid = 0; m_y = '0;
    end else begin
      rdy = (m_cnt < 0) || (m_cnt == TAPS - 1);
      m_valid = 0;
      if (m_cnt == TAPS - 1) begin
        s = BIAS;
        for (int k = 0; k < TAPS; k++) s += longint'(hist[k]) * longint'(TB_COEFS[k]);
        t = s >>> FRAC;
        m_y = t[OUT_W-1:0];
        m_valid = 1;
      end
      if (in_valid && rdy) begin
        hist.push_front(int'($signed(in_data)));
        void'(hist.pop_back());
        m_cnt = 0;
      end else if (m_cnt == TAPS - 1) m_cnt = -1;
      else if (m_cnt >= 0) m_cnt++;
    end
  end

  function automatic bit exp_ready();
    return (m_cnt < 0) || (m_cnt == TAPS - 1);
  endfunction

  // every-cycle comparison, mid-cycle
  int last_pulse = -1;
  always @(negedge clk) begin
    if (checking && !done) begin
      total++;
      if (in_ready !== exp_ready()) begin
        bad++;
        $display("FAIL R2 [%s] in_ready=%0b exp=%0b", phase, in_ready, exp_ready());
      end
      total++;
      if (out_valid !== m_valid) begin
        bad++;
        $display("FAIL R4 [%s] out_valid=%0b exp=%0b", phase, out_valid, m_valid);
      end
      total++;
      if (out_y !== m_y) begin
        bad++;
        $display("FAIL R5 R7 [%s] out_y=%0d exp=%0d", phase,
                 $signed(out_y), $signed(m_y));
      end
      if (out_valid) begin
        if (b2b && last_pulse >= 0) begin
          total++;
          if (cyc - last_pulse != TAPS) begin
            bad++;
            $display("FAIL R9 [%s] gap=%0d exp=%0d", phase, cyc - last_pulse, TAPS);
          end
        end
        last_pulse = cyc;
      end
    end
  end

  task automatic summary();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      bad++;
      $display("FAIL R4 watchdog: run stalled at cycle %0d exp finish before %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: port state after reset, before any input
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || out_y !== '0) begin
      bad++;
      $display("FAIL R1 reset state valid=%0b ready=%0b y=%0d exp 0 1 0",
               out_valid, in_ready, out_y);
    end
    checking = 1;
    b2b = 1;

    // R6 R5: impulses of 1 and of one half, surrounded by zeros
    phase = "R6 impulse";
    in_valid = 1'b1;
    for (int i = 0; i < 40 * TAPS; i++) begin
      in_data = (i == 0) ? 16'd1 : (i == 20 * TAPS) ? 16'd16384 : 16'd0;
      @(negedge clk);
    end

    // R9: constant step with the input always valid
    phase = "R9 step";
    in_data = 16'd10000;
    repeat (20 * TAPS * TAPS) @(negedge clk);

    // R8 R7: full-scale negative, sum wraps in the 16-bit output
    phase = "R8 full-scale negative";
    in_data = 16'h8000;
    repeat (20 * TAPS * TAPS) @(negedge clk);

    // R3: data changes every cycle, including while in_ready is low
    phase = "R3 busy offers";
    for (int i = 0; i < 30 * TAPS * TAPS; i++) begin
      step_lfsr();
      in_data = lfsr;
      @(negedge clk);
    end

    // R5 R2: random gaps in the offered stream
    phase = "R5 random gaps";
    b2b = 0;
    for (int i = 0; i < 40 * TAPS * TAPS; i++) begin
      step_lfsr();
      in_valid = lfsr[3] ^ lfsr[9];
      in_data = {lfsr[7:0], lfsr[15:8]};
      @(negedge clk);
    end

    in_valid = 1'b0;
    phase = "R4 drain";
    repeat (3 * TAPS) @(negedge clk);
    summary();
  end

endmodule